// File: doc/BRIEF.md
# Debug Emulation Pin Signalling

This block drives one active-low, open-drain debug status pin from the core clock domain. It also turns rising edges of the test-mode-select line into emulation exception requests. The pin is shared as a wired-OR between devices, so the block only ever requests the pad to pull low and never drives it high. Two kinds of indication share the pin. A watchpoint event that raises no exception produces a low pulse of fixed length. When the core enters emulation mode and is ready for a new instruction, the pin goes low and stays low until the debugger writes the emulation instruction register.

An output-enable control bit gates the pad drive. A separate enable bit turns TMS edge detection into an exception source. TMS keeps its ordinary test-port role while this happens, because the block only observes it. TMS is resynchronised into the core clock domain before its edges are detected. The TAP state machine, the scan chains and instruction execution belong to other blocks.

Top module: `emu_pin_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, emu_pad_drive_o and emu_exc_o are 0. Reset clears the pulse counter and the awaiting-instruction state.
- R2: A watchpoint event with exception type 2'b00 (no exception), sampled on a clock edge, asserts emu_pad_drive_o from that edge for exactly PULSE_LEN (default 20) cycles.
- R3: A watchpoint event with exception type 2'b01, 2'b10 or 2'b11 starts no pulse and has no effect on emu_pad_drive_o.
- R4: A zero-type watchpoint event that arrives while a pulse is running restarts the pulse at full length. The pin then stays asserted for PULSE_LEN cycles from the new event.
- R5: The ready condition is emu_mode_i and instr_rdy_i both high. A rising edge of this condition asserts the awaiting-instruction level. The level holds until a sampled instr_wr_i ends it, effective after that edge, or until the ready condition drops.
- R6: If instr_wr_i is sampled on the same edge where the ready condition rises, the awaiting level is not entered and the pin is not asserted.
- R7: While emu_oe_i is 0, emu_pad_drive_o is 0. The pulse counter keeps running underneath, so raising emu_oe_i during a pulse shows only the remaining cycles of that pulse.
- R8: With tms_exc_en_i high, each 0-to-1 transition of tms_i gives emu_exc_o high for exactly one cycle, two core clock edges after the change (synchroniser delay). Falling edges give no request. With tms_exc_en_i low, emu_exc_o stays 0.
- R9: emu_pad_drive_o is the OR of the watchpoint pulse and the awaiting level. A pulse that ends while the awaiting level is active leaves the pin asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| emu_oe_i | input | 1 | Permits the pad to be pulled low |
| tms_exc_en_i | input | 1 | Makes TMS rising edges raise exceptions |
| wp_evt_i | input | 1 | Watchpoint event strobe |
| wp_exc_type_i | input | 2 | Exception type of the event; 2'b00 means none |
| emu_mode_i | input | 1 | Core is in emulation mode |
| instr_rdy_i | input | 1 | Core is ready for a new instruction line |
| instr_wr_i | input | 1 | Write strobe of the emulation instruction register |
| tms_i | input | 1 | Test-mode-select line, asynchronous to clk_i |
| emu_pad_drive_o | output | 1 | Pad pull-down enable; high pulls the pin low |
| emu_exc_o | output | 1 | One-cycle emulation exception request |

## Verification
Some rules are checked by the assertions on every cycle. The pin stays released while output enable is low. The pulse counter counts down by one and never exceeds its length. A zero-type event is always followed by drive when enabled, and a non-zero type starts nothing from idle. An instruction write always clears the awaiting level. An exception request never lasts two cycles, and none appears while disabled. Other properties need the bench's scenarios, compared cycle by cycle against a behavioural model. These are the exact pulse length, the restart on retrigger and the race between the write and the ready edge. They also include the visible remainder after a late output enable, the pin held by the awaiting level past the end of a pulse, and the two-edge latency of TMS edges.

// File: rtl/emu_pin_pkg.sv
package emu_pin_pkg;
  localparam int unsigned EXC_W = 2;
  typedef logic [EXC_W-1:0] exc_type_t;
  localparam exc_type_t EXC_NONE = '0;
endpackage

// File: rtl/emu_tms_edge.sv
module emu_tms_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tms_i,
  input  logic en_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tms_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = en_i & sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/emu_wp_pulse.sv
module emu_wp_pulse
  import emu_pin_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 20,
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  exc_type_t        type_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             load;

  assign load = evt_i && (type_i == EXC_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load)             cnt_q <= CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/emu_await_instr.sv
module emu_await_instr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic emu_mode_i,
  input  logic instr_rdy_i,
  input  logic instr_wr_i,
  output logic await_o
);
  logic cond, cond_q, await_q, await_d;

  assign cond = emu_mode_i & instr_rdy_i;

  // write wins over a coincident ready edge
  always_comb begin
    if (instr_wr_i || !cond) await_d = 1'b0;
    else if (!cond_q)        await_d = 1'b1;
    else                     await_d = await_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q  <= 1'b0;
      await_q <= 1'b0;
    end else begin
      cond_q  <= cond;
      await_q <= await_d;
    end
  end

  assign await_o = await_q;
endmodule

// File: rtl/emu_pin_ctrl.sv
module emu_pin_ctrl
  import emu_pin_pkg::*;
#(
  parameter int unsigned PULSE_LEN   = 20,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            emu_oe_i,
  input  logic            tms_exc_en_i,
  input  logic            wp_evt_i,
  input  logic [EXC_W-1:0] wp_exc_type_i,
  input  logic            emu_mode_i,
  input  logic            instr_rdy_i,
  input  logic            instr_wr_i,
  input  logic            tms_i,
  output logic            emu_pad_drive_o,
  output logic            emu_exc_o
);
  logic             pulse_act;
  logic [CNT_W-1:0] pulse_cnt;
  logic             await_lvl;

  emu_wp_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (wp_evt_i),
    .type_i   (wp_exc_type_i),
    .active_o (pulse_act),
    .cnt_o    (pulse_cnt)
  );

  emu_await_instr u_await (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .emu_mode_i  (emu_mode_i),
    .instr_rdy_i (instr_rdy_i),
    .instr_wr_i  (instr_wr_i),
    .await_o     (await_lvl)
  );

  emu_tms_edge #(.STAGES(SYNC_STAGES)) u_tms (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tms_i  (tms_i),
    .en_i   (tms_exc_en_i),
    .rise_o (emu_exc_o)
  );

  // pad only ever pulls low; release otherwise
  assign emu_pad_drive_o = emu_oe_i & (pulse_act | await_lvl);
endmodule

// File: rtl/emu_pin_ctrl_chk.sv
module emu_pin_ctrl_chk #(
  parameter int unsigned PULSE_LEN = 20,
  parameter int unsigned CNT_W     = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             emu_oe_i,
  input logic             tms_exc_en_i,
  input logic             wp_evt_i,
  input logic [1:0]       wp_exc_type_i,
  input logic             instr_wr_i,
  input logic             emu_pad_drive_o,
  input logic             emu_exc_o,
  input logic [CNT_W-1:0] pulse_cnt,
  input logic             await_lvl
);
  // R7
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emu_oe_i |-> !emu_pad_drive_o);

  // R2
  wp_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_evt_i && wp_exc_type_i == 2'b00) |=> (!emu_oe_i || emu_pad_drive_o));

  // R4
  cnt_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_cnt != '0 && !(wp_evt_i && wp_exc_type_i == 2'b00))
      |=> (pulse_cnt == $past(pulse_cnt) - 1'b1));

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_cnt <= CNT_W'(PULSE_LEN));

  // R3
  wp_typed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_cnt == '0 && !(wp_evt_i && wp_exc_type_i == 2'b00)) |=> pulse_cnt == '0);

  // R5
  wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_wr_i |=> !await_lvl);

  // R8
  exc_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emu_exc_o |=> !emu_exc_o);

  // R8
  exc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tms_exc_en_i |-> !emu_exc_o);
endmodule

bind emu_pin_ctrl emu_pin_ctrl_chk #(.PULSE_LEN(PULSE_LEN), .CNT_W(CNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .emu_oe_i        (emu_oe_i),
  .tms_exc_en_i    (tms_exc_en_i),
  .wp_evt_i        (wp_evt_i),
  .wp_exc_type_i   (wp_exc_type_i),
  .instr_wr_i      (instr_wr_i),
  .emu_pad_drive_o (emu_pad_drive_o),
  .emu_exc_o       (emu_exc_o),
  .pulse_cnt       (pulse_cnt),
  .await_lvl       (await_lvl)
);

// File: tb/tb_emu_pin_ctrl.sv
module tb_emu_pin_ctrl;
  localparam int LEN = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic oe = 0, tms_en = 0, wp_evt = 0, emu = 0, rdy = 0, wr = 0, tms = 0;
  logic [1:0] wp_type = 2'b00;
  logic drive, exc;

  int total = 0, bad = 0;
  int drive_cycles = 0, exc_cnt = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  emu_pin_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .emu_oe_i(oe), .tms_exc_en_i(tms_en),
    .wp_evt_i(wp_evt), .wp_exc_type_i(wp_type), .emu_mode_i(emu),
    .instr_rdy_i(rdy), .instr_wr_i(wr), .tms_i(tms),
    .emu_pad_drive_o(drive), .emu_exc_o(exc)
  );

  // behavioural reference
  int m_cnt;
  bit m_await, m_cond_prev;
  bit m_tms[$];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_await = 0; m_cond_prev = 0;
      m_tms = '{0, 0, 0};
    end else begin
      bit c;
      if (wp_evt && wp_type == 2'b00) m_cnt = LEN;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      c = emu && rdy;
      if (wr || !c) m_await = 0;
      else if (!m_cond_prev) m_await = 1;
      m_cond_prev = c;
      m_tms.push_front(tms);
      void'(m_tms.pop_back());
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit e_drv, e_exc;
      e_drv = rst_n && oe && (m_cnt > 0 || m_await);
      e_exc = rst_n && tms_en && m_tms[1] && !m_tms[2];
      chk(drive === e_drv, {cur_req, " drive"}, int'(drive), int'(e_drv));
      chk(exc === e_exc, {cur_req, " exc"}, int'(exc), int'(e_exc));
      if (drive) drive_cycles++;
      if (exc) exc_cnt++;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset
    cur_req = "R1";
    oe = 1; tms_en = 1;
    tick(3);
    chk(drive === 1'b0 && exc === 1'b0, "R1 during reset", int'(drive), 0);
    rst_n = 1;
    tick(1);
    chk(drive === 1'b0, "R1 after release", int'(drive), 0);
    tms_en = 0;
    tick(2);

    // R2 single pulse length
    cur_req = "R2";
    drive_cycles = 0;
    wp_evt = 1; wp_type = 2'b00; tick(1); wp_evt = 0;
    tick(25);
    chk(drive_cycles == LEN, "R2 pulse length", drive_cycles, LEN);

    // R3 typed events start nothing
    cur_req = "R3";
    drive_cycles = 0;
    for (int t = 1; t < 4; t++) begin
      wp_evt = 1; wp_type = 2'(t); tick(1); wp_evt = 0; tick(3);
    end
    wp_type = 2'b00;
    chk(drive_cycles == 0, "R3 typed events", drive_cycles, 0);

    // R4 retrigger
    cur_req = "R4";
    drive_cycles = 0;
    wp_evt = 1; tick(1); wp_evt = 0; tick(9);
    wp_evt = 1; tick(1); wp_evt = 0; tick(25);
    chk(drive_cycles == 30, "R4 retrigger", drive_cycles, 30);

    // R5 awaiting level
    cur_req = "R5";
    emu = 1; rdy = 1; tick(15);
    chk(drive === 1'b1, "R5 held", int'(drive), 1);
    wr = 1; tick(1); wr = 0;
    chk(drive === 1'b0, "R5 released by write", int'(drive), 0);
    tick(3);
    chk(drive === 1'b0, "R5 stays released", int'(drive), 0);
    emu = 0; rdy = 0; tick(2);
    emu = 1; rdy = 1; tick(4);
    rdy = 0; tick(1);
    chk(drive === 1'b0, "R5 ready drop", int'(drive), 0);
    emu = 0; tick(2);

    // R6 coincident write
    cur_req = "R6";
    drive_cycles = 0;
    emu = 1; rdy = 1; wr = 1; tick(1); wr = 0;
    tick(10);
    chk(drive_cycles == 0, "R6 coincident write", drive_cycles, 0);
    emu = 0; rdy = 0; tick(2);

    // R7 output enable gating
    cur_req = "R7";
    oe = 0; drive_cycles = 0;
    wp_evt = 1; tick(1); wp_evt = 0; tick(4);
    chk(drive_cycles == 0, "R7 oe low", drive_cycles, 0);
    oe = 1; tick(20);
    chk(drive_cycles == LEN - 4, "R7 remainder", drive_cycles, LEN - 4);

    // R9 overlap of pulse and level
    cur_req = "R9";
    wp_evt = 1; emu = 1; rdy = 1; tick(1); wp_evt = 0;
    tick(30);
    chk(drive === 1'b1, "R9 level outlasts pulse", int'(drive), 1);
    wr = 1; tick(1); wr = 0;
    chk(drive === 1'b0, "R9 release", int'(drive), 0);
    emu = 0; rdy = 0; tick(2);

    // R8 TMS edges
    cur_req = "R8";
    tms_en = 1; exc_cnt = 0;
    repeat (5) begin tms = 1; tick(4); tms = 0; tick(4); end
    chk(exc_cnt == 5, "R8 enabled edges", exc_cnt, 5);
    tms = 1; tick(1);
    chk(exc === 1'b0, "R8 latency one edge", int'(exc), 0);
    tick(1);
    chk(exc === 1'b1, "R8 latency two edges", int'(exc), 1);
    tick(1);
    chk(exc === 1'b0, "R8 single cycle", int'(exc), 0);
    tms = 0; tick(4);
    tms_en = 0; exc_cnt = 0;
    repeat (3) begin tms = 1; tick(4); tms = 0; tick(4); end
    chk(exc_cnt == 0, "R8 disabled", exc_cnt, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule